// File: doc/BRIEF.md
# Microprocessor Bus Cycle Sequencer

This block turns a single bus request from an 8-bit processor core into the external control waveforms for one bus cycle. The processor has a 16-bit address bus and active-low strobes. The core chooses one of four cycle shapes: an opcode fetch, a memory read or write, an I/O read or write, or an interrupt acknowledge. The sequencer then steps through the T-states, one clock per T-state. It drives the address, the memory and I/O request strobes, read and write, the fetch marker and the refresh strobe.

A slow device can stretch a cycle by holding the active-low wait input. Each cycle shape has its own fixed point at which that input is sampled. I/O and acknowledge cycles already contain built-in wait states before that point. Fetch and acknowledge cycles end with a refresh phase, which puts the latched refresh address on the bus. When a cycle completes, the block raises a one-clock done pulse together with the byte it captured from the data bus. A request is taken only while the sequencer is idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: In reset and whenever no cycle is running, every strobe (m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n) is high, data_oe is 0, busy is 0 and done is 0.
- R2: A request (req_valid high) is taken at a clock edge only while req_ready is high (sequencer idle). A req_valid pulse raised while a cycle is running has no effect, and no cycle follows it.
- R3: Opcode fetch (req_kind = 0) without waits lasts 4 T-states. In T-states 1–2, req_addr is on the address bus and m1_n, mreq_n and rd_n are low. In T-states 3–4, refresh_addr is on the bus, mreq_n and rfsh_n are low, and m1_n and rd_n are high. The opcode is captured at the end of T-state 2.
- R4: Memory read (req_kind = 1, req_write = 0) lasts 3 T-states, with mreq_n and rd_n low throughout. The data is captured at the end of the last T-state.
- R5: Memory write (req_kind = 1, req_write = 1) lasts 3 T-states. mreq_n is low throughout. wr_n is low only from the second T-state on. data_oe is high for the whole cycle, with data_out equal to req_wdata.
- R6: I/O cycle (req_kind = 2) lasts 4 T-states, one of which is a built-in wait state. The first T-state has no strobe low. From the second T-state to the end, iorq_n and rd_n (read) or wr_n (write) are low. Read data is captured at the end. Writes drive data_oe for the whole cycle.
- R7: Interrupt acknowledge (req_kind = 3) lasts 6 T-states. m1_n is low for the first 4 T-states and iorq_n is low in T-states 3–4. The vector byte is captured at the end of T-state 4. The last 2 T-states are a refresh phase with mreq_n and rfsh_n low and refresh_addr on the bus.
- R8: wait_n is sampled at the end of the 2nd T-state (fetch, memory), the 3rd (I/O) or the 4th (acknowledge), and at the end of each inserted wait state. Each low sample inserts one more T-state that repeats the strobes of the sampled T-state. The cycle grows by the number of low samples.
- R9: done is high for exactly one clock, in the clock after the final T-state. For read-type cycles, rdata holds the captured byte in that clock.
- R10: rd_n and wr_n are never low together, and mreq_n and iorq_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 2 | 0 fetch, 1 memory, 2 I/O, 3 interrupt acknowledge |
| req_write | input | 1 | Write for memory and I/O cycles |
| req_addr | input | 16 | Cycle address (program counter or port) |
| req_wdata | input | 8 | Write data |
| refresh_addr | input | 16 | Refresh address for the refresh phase |
| wait_n | input | 1 | Active-low wait request |
| data_in | input | 8 | Data bus input |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Captured data byte |
| addr_o | output | 16 | Address bus |
| data_out | output | 8 | Data bus output |
| data_oe | output | 1 | Data bus output enable |
| m1_n | output | 1 | Fetch / acknowledge marker |
| mreq_n | output | 1 | Memory request |
| iorq_n | output | 1 | I/O request |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| rfsh_n | output | 1 | Refresh strobe |

## Verification
The assertions guard rules that hold on every clock, whatever the cycle:
- strobes are quiet while idle;
- read and write, and memory and I/O requests, never overlap;
- refresh never coincides with a fetch or read strobe;
- the data bus is driven only for writes;
- a low wait sample holds the wait state;
- done lasts a single clock.

Only the bench scenarios show what depends on the cycle shape:
- the exact T-state at which each strobe falls and rises;
- cycle length with and without wait states;
- the switch to the refresh address;
- which byte is captured;
- that a request raised mid-cycle is dropped.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_MEM   = 2'd1,
        CYC_IO    = 2'd2,
        CYC_INTA  = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TA1  = 3'd3,
        PH_TA2  = 3'd4,
        PH_TW   = 3'd5,
        PH_T3   = 3'd6,
        PH_T4   = 3'd7
    } phase_e;

    typedef struct packed {
        logic m1_n;
        logic mreq_n;
        logic iorq_n;
        logic rd_n;
        logic wr_n;
        logic rfsh_n;
    } strobes_t;

    localparam strobes_t STROBES_QUIET = '1;

    function automatic logic has_refresh(cyc_kind_e k);
        return (k == CYC_FETCH) || (k == CYC_INTA);
    endfunction

    // T-state at whose end wait_n is sampled
    function automatic logic sample_point(cyc_kind_e k, phase_e p);
        logic hit;
        if (p == PH_TW) begin
            hit = 1'b1;
        end else begin
            case (k)
                CYC_FETCH, CYC_MEM: hit = (p == PH_T2);
                CYC_IO:             hit = (p == PH_TA1);
                default:            hit = (p == PH_TA2);
            endcase
        end
        return hit;
    endfunction

    // Successor of a phase that is not a sample point
    function automatic phase_e plain_next(cyc_kind_e k, phase_e p);
        phase_e n;
        case (p)
            PH_T1:   n = PH_T2;
            PH_T2:   n = PH_TA1;
            PH_TA1:  n = PH_TA2;
            PH_T3:   n = has_refresh(k) ? PH_T4 : PH_IDLE;
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

    function automatic logic final_phase(cyc_kind_e k, phase_e p);
        return has_refresh(k) ? (p == PH_T4) : (p == PH_T3);
    endfunction

    function automatic logic refresh_phase(cyc_kind_e k, phase_e p);
        return has_refresh(k) && ((p == PH_T3) || (p == PH_T4));
    endfunction

    function automatic strobes_t decode_strobes(cyc_kind_e k, logic wr, phase_e p);
        strobes_t s;
        s = STROBES_QUIET;
        if (p != PH_IDLE) begin
            case (k)
                CYC_FETCH: begin
                    if (p == PH_T3 || p == PH_T4) begin
                        s.mreq_n = 1'b0;
                        s.rfsh_n = 1'b0;
                    end else begin
                        s.m1_n   = 1'b0;
                        s.mreq_n = 1'b0;
                        s.rd_n   = 1'b0;
                    end
                end
                CYC_MEM: begin
                    s.mreq_n = 1'b0;
                    if (!wr)             s.rd_n = 1'b0;
                    else if (p != PH_T1) s.wr_n = 1'b0;
                end
                CYC_IO: begin
                    if (p != PH_T1) begin
                        s.iorq_n = 1'b0;
                        if (wr) s.wr_n = 1'b0;
                        else    s.rd_n = 1'b0;
                    end
                end
                default: begin
                    if (p == PH_T3 || p == PH_T4) begin
                        s.mreq_n = 1'b0;
                        s.rfsh_n = 1'b0;
                    end else begin
                        s.m1_n = 1'b0;
                        if (p == PH_TA1 || p == PH_TA2 || p == PH_TW)
                            s.iorq_n = 1'b0;
                    end
                end
            endcase
        end
        return s;
    endfunction

    function automatic logic drives_data(cyc_kind_e k, logic wr, phase_e p);
        return wr && (k == CYC_MEM || k == CYC_IO) && (p != PH_IDLE);
    endfunction

endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  cyc_kind_e kind,
    input  logic      wait_n,
    output phase_e    phase
);
    phase_e phase_nxt;

    always_comb begin
        phase_nxt = phase;
        if (phase == PH_IDLE) begin
            if (start) phase_nxt = PH_T1;
        end else if (sample_point(kind, phase)) begin
            phase_nxt = wait_n ? PH_T3 : PH_TW;
        end else begin
            phase_nxt = plain_next(kind, phase);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nxt;
    end

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TW && !wait_n) |=> (phase == PH_TW)); // R8

    AST_T1_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T1) |-> ($past(phase) == PH_IDLE)); // R2

endmodule

// File: rtl/bseq_drive.sv
module bseq_drive
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cyc_kind_e         req_kind,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    output cyc_kind_e         kind_q,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output strobes_t          strobes
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= CYC_FETCH;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            ref_q    <= '0;
            data_out <= '0;
        end else if (start) begin
            kind_q   <= req_kind;
            wr_q     <= req_write && (req_kind == CYC_MEM || req_kind == CYC_IO);
            addr_q   <= req_addr;
            ref_q    <= ref_addr;
            data_out <= req_wdata;
        end
    end

    always_comb begin
        strobes = decode_strobes(kind_q, wr_q, phase);
        data_oe = drives_data(kind_q, wr_q, phase);
        addr_o  = refresh_phase(kind_q, phase) ? ref_q : addr_q;
    end

    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!strobes.rd_n && !strobes.wr_n)); // R10

    AST_MEM_IO_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!strobes.mreq_n && !strobes.iorq_n)); // R10

    AST_RFSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        !strobes.rfsh_n |-> (strobes.m1_n && strobes.rd_n)); // R3

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> strobes.rd_n); // R5

endmodule

// File: rtl/bseq_capture.sv
module bseq_capture
    import bseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_kind_e         kind,
    input  logic              wr,
    input  phase_e            phase,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    logic take;

    always_comb begin
        if (phase == PH_IDLE)
            take = 1'b0;
        else if (has_refresh(kind))
            take = sample_point(kind, phase) && wait_n;
        else
            take = (phase == PH_T3) && !wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            if (take) rdata <= data_in;
            done <= (phase != PH_IDLE) && final_phase(kind, phase);
        end
    end

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [ADDR_W-1:0] refresh_addr,
    input  logic              wait_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              m1_n,
    output logic              mreq_n,
    output logic              iorq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              rfsh_n
);
    phase_e    phase;
    cyc_kind_e kind_q;
    logic      wr_q;
    logic      start;
    strobes_t  strobes;

    assign req_ready = (phase == PH_IDLE);
    assign busy      = (phase != PH_IDLE);
    assign start     = req_valid && req_ready;

    bseq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .kind   (kind_q),
        .wait_n (wait_n),
        .phase  (phase)
    );

    bseq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_kind  (cyc_kind_e'(req_kind)),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ref_addr  (refresh_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .kind_q    (kind_q),
        .wr_q      (wr_q),
        .addr_o    (addr_o),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .strobes   (strobes)
    );

    bseq_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind_q),
        .wr      (wr_q),
        .phase   (phase),
        .wait_n  (wait_n),
        .data_in (data_in),
        .rdata   (rdata),
        .done    (done)
    );

    assign m1_n   = strobes.m1_n;
    assign mreq_n = strobes.mreq_n;
    assign iorq_n = strobes.iorq_n;
    assign rd_n   = strobes.rd_n;
    assign wr_n   = strobes.wr_n;
    assign rfsh_n = strobes.rfsh_n;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (strobes == STROBES_QUIET && !data_oe)); // R1

endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [15:0] refresh_addr = '0;
    logic        wait_n = 1'b1;
    logic [7:0]  data_in;
    logic        req_ready, busy, done, data_oe;
    logic [7:0]  rdata, data_out;
    logic [15:0] addr_o;
    logic        m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n;

    localparam logic [7:0] VEC_BYTE = 8'hE7;

    always #2 clk = ~clk;   // 250 MHz

    bus_cycle_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .refresh_addr(refresh_addr), .wait_n(wait_n), .data_in(data_in),
        .req_ready(req_ready), .busy(busy), .done(done), .rdata(rdata),
        .addr_o(addr_o), .data_out(data_out), .data_oe(data_oe),
        .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .wr_n(wr_n), .rfsh_n(rfsh_n)
    );

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] io_byte(logic [15:0] a);
        return ~a[7:0];
    endfunction

    // Device model on the bus
    always_comb begin
        if (!m1_n && !iorq_n)       data_in = VEC_BYTE;
        else if (!iorq_n && !rd_n)  data_in = io_byte(addr_o);
        else if (!mreq_n && !rd_n)  data_in = mem_byte(addr_o);
        else                        data_in = 8'h00;
    end

    typedef struct packed {
        logic [1:0]  kind;
        logic        wr;
        logic [15:0] addr;
        logic [15:0] rf;
        logic [7:0]  wdata;
        logic [3:0]  n;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(item_t it);
        if (it.n != 0) return "R8";
        case (it.kind)
            2'd0: return "R3";
            2'd1: return it.wr ? "R5" : "R4";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic int exp_len(item_t it);
        case (it.kind)
            2'd0: return 4 + int'(it.n);
            2'd1: return 3 + int'(it.n);
            2'd2: return 4 + int'(it.n);
            default: return 6 + int'(it.n);
        endcase
    endfunction

    // {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}
    function automatic logic [5:0] exp_strb(item_t it, int off);
        logic m1, mr, io, rd, wr, rf;
        int n;
        n = int'(it.n);
        {m1, mr, io, rd, wr, rf} = 6'b111111;
        case (it.kind)
            2'd0: if (off < 2 + n) {m1, mr, rd} = 3'b000; else {mr, rf} = 2'b00;
            2'd1: begin
                mr = 1'b0;
                if (it.wr) begin if (off >= 1) wr = 1'b0; end
                else rd = 1'b0;
            end
            2'd2: if (off >= 1) begin
                io = 1'b0;
                if (it.wr) wr = 1'b0; else rd = 1'b0;
            end
            default: begin
                if (off < 4 + n) m1 = 1'b0;
                if (off >= 2 && off < 4 + n) io = 1'b0;
                if (off >= 4 + n) {mr, rf} = 2'b00;
            end
        endcase
        return {m1, mr, io, rd, wr, rf};
    endfunction

    function automatic logic [15:0] exp_addr(item_t it, int off);
        if (it.kind == 2'd0 && off >= 2 + int'(it.n)) return it.rf;
        if (it.kind == 2'd3 && off >= 4 + int'(it.n)) return it.rf;
        return it.addr;
    endfunction

    function automatic logic [7:0] exp_data(item_t it);
        case (it.kind)
            2'd0, 2'd1: return mem_byte(it.addr);
            2'd2: return io_byte(it.addr);
            default: return VEC_BYTE;
        endcase
    endfunction

    // Monitor: compares each T-state and the completion against the queue head
    int off = 0;
    bit bad_strb = 0, bad_addr = 0, bad_oe = 0, bad_excl = 0, pend_done = 0;
    item_t cur;
    logic [5:0] first_bad_strb = '0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (pend_done) begin
                chk(!done, "R9 done width", int'(done), 0);
                pend_done = 0;
            end
            if (busy && q.size() > 0) begin
                cur = q[0];
                if ({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n} != exp_strb(cur, off)) begin
                    if (!bad_strb) first_bad_strb = {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n};
                    bad_strb = 1;
                end
                if (addr_o != exp_addr(cur, off)) bad_addr = 1;
                if (data_oe != (cur.wr && (cur.kind == 2'd1 || cur.kind == 2'd2))) bad_oe = 1;
                if (data_oe && data_out != cur.wdata) bad_oe = 1;
                if ((!rd_n && !wr_n) || (!mreq_n && !iorq_n)) bad_excl = 1;
                off++;
            end
            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected done", 1, 0);
                end else begin
                    cur = q.pop_front();
                    chk(off == exp_len(cur), {tag_of(cur), " length"}, off, exp_len(cur));
                    chk(!bad_strb, {tag_of(cur), " strobes"}, int'(first_bad_strb), int'(exp_strb(cur, 0)));
                    chk(!bad_addr, {tag_of(cur), " address"}, int'(bad_addr), 0);
                    chk(!bad_excl, "R10 overlap", int'(bad_excl), 0);
                    if (cur.wr && (cur.kind == 2'd1 || cur.kind == 2'd2))
                        chk(!bad_oe, {tag_of(cur), " write data"}, int'(bad_oe), 0);
                    else
                        chk(rdata == exp_data(cur), {"R9 ", tag_of(cur), " rdata"}, int'(rdata), int'(exp_data(cur)));
                end
                off = 0; bad_strb = 0; bad_addr = 0; bad_oe = 0; bad_excl = 0;
                pend_done = 1;
            end
        end
    end

    // Driver: pushes the expected item, then issues the request and the wait pattern
    task automatic run(input logic [1:0] kind, input logic wr, input logic [15:0] addr,
                       input logic [7:0] wd, input logic [15:0] rf, input int n, input bit intrude);
        item_t it;
        int s;
        it.kind = kind; it.wr = wr; it.addr = addr; it.rf = rf; it.wdata = wd; it.n = 4'(n);
        q.push_back(it);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_write = wr; req_addr = addr;
        req_wdata = wd; refresh_addr = rf;
        @(negedge clk);      // T-state 1
        req_valid = 1'b0;
        s = (kind == 2'd0 || kind == 2'd1) ? 1 : (kind == 2'd2 ? 2 : 3);
        if (intrude) begin
            req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'hBEEF; req_write = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
        end else if (n > 0) begin
            repeat (s) @(negedge clk);
            wait_n = 1'b0;
            repeat (n) @(negedge clk);
            wait_n = 1'b1;
        end
        forever begin
            @(negedge clk);
            if (done) break;
        end
        if (intrude) begin
            @(negedge clk);
            chk(!busy, "R2 mid-cycle request ignored", int'(busy), 0);
            chk(req_ready, "R2 ready after cycle", int'(req_ready), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n} == 6'h3F, "R1 strobes in reset",
            int'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 'h3F);
        chk(!busy && !done && !data_oe, "R1 idle flags in reset", int'({busy, done, data_oe}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n} == 6'h3F && req_ready, "R1 idle after reset",
            int'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 'h3F);

        run(2'd0, 1'b0, 16'h1234, 8'h00, 16'h3F55, 0, 0);   // R3
        run(2'd1, 1'b0, 16'h8001, 8'h00, 16'h0000, 0, 0);   // R4
        run(2'd1, 1'b1, 16'h4002, 8'hA5, 16'h0000, 0, 0);   // R5
        run(2'd2, 1'b0, 16'h00C3, 8'h00, 16'h0000, 0, 0);   // R6
        run(2'd2, 1'b1, 16'h0071, 8'h3C, 16'h0000, 0, 0);   // R6
        run(2'd3, 1'b0, 16'h2468, 8'h00, 16'h4A12, 0, 0);   // R7
        run(2'd0, 1'b0, 16'hC0DE, 8'h00, 16'h1177, 2, 0);   // R8
        run(2'd1, 1'b0, 16'h7E10, 8'h00, 16'h0000, 1, 0);   // R8
        run(2'd1, 1'b1, 16'h55AA, 8'h96, 16'h0000, 3, 0);   // R8
        run(2'd2, 1'b0, 16'h10FE, 8'h00, 16'h0000, 2, 0);   // R8
        run(2'd3, 1'b0, 16'h0F0F, 8'h00, 16'h2299, 1, 0);   // R8
        run(2'd0, 1'b0, 16'h6502, 8'h00, 16'h0303, 0, 1);   // R2
        run(2'd1, 1'b0, 16'hFFFF, 8'h00, 16'h0000, 0, 0);   // R4 boundary address
        run(2'd1, 1'b0, 16'h0000, 8'h00, 16'h0000, 0, 0);   // R4 back-to-back

        @(negedge clk);
        chk(q.size() == 0, "R9 all cycles completed", q.size(), 0);
        chk({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n} == 6'h3F && !data_oe, "R1 quiet between cycles",
            int'({m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n}), 'h3F);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule